// File: doc/BRIEF.md
# Serial Command-Frame Slave Port

This block is the serial front end of a 16-bit converter. A host writes frames of 24 bits while holding an active-low chip select: an 8-bit command byte followed by a 16-bit data word, each sent most significant bit first. The port samples the serial clock, chip select and data input into a faster system clock domain through two-flop synchronizers. The system clock must run at least four times faster than the serial clock. Edges are found by comparing successive synchronized samples.

A continuous 24-bit shift register keeps the most recent bits received, including bits left over from earlier frames. Its oldest bit drives the serial data output. Data is captured on rising serial clock edges, and the output advances on falling edges. The host can therefore read back the previous frame while it sends a new one, and several ports can be chained output-to-input on a shared clock and select. The output is driven only while the port is selected. A separate enable models the high-impedance state.

When chip select returns high, the port checks how many rising edges fell inside the window. If the count is a nonzero whole multiple of 24, it presents the command byte and data word to the register block with a one-cycle commit strobe. Otherwise it raises a one-cycle frame error strobe instead. Counting in multiples of 24 lets every port in a chain commit on the shared select.

Top module: `cmdframe_spi_slave`

## Requirements
- R1: A falling chip select starts a frame. The first bit received is the command MSB (bit 7 of `cmd_o`), and the last is the data LSB (bit 0 of `data_o`).
- R2: While selected, each rising serial clock edge shifts the data input into a 24-bit register. The register keeps the newest 24 bits across frame boundaries.
- R3: When chip select rises after a window of k rising edges, where k is a nonzero multiple of 24, `commit_o` pulses for exactly one cycle. At that pulse, `cmd_o` holds register bits 23..16 and `data_o` holds bits 15..0.
- R4: For any other edge count, including zero, `frame_err_o` pulses for one cycle and `commit_o` stays low. The bits already shifted in stay in the register.
- R5: `dout_o` carries register bit 23. It is loaded when the frame starts and again on every falling serial clock edge while the port is selected.
- R6: `dout_oe_o` is low whenever chip select has been high for the synchronizer latency, and high while the port is selected.
- R7: Both clock-idle-low (sample on the first edge) and clock-idle-high (shift on the first edge) framing produce identical captured bits and output bits.
- R8: The 24 bits shifted in during one select window appear on `dout_o`, MSB first, during the next window.
- R9: Two ports chained output-to-input, with a 48-edge window, commit the first 24 bits in the downstream port and the last 24 bits in the upstream port.
- R10: After reset, the register is zero, `dout_o` and `dout_oe_o` are 0, and neither strobe is active.
- R11: Serial clock edges while chip select is high change neither the register nor the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial data input |
| dout_o | output | 1 | Serial data output (MSB of the shift register) |
| dout_oe_o | output | 1 | Output enable for `dout_o`; low means high impedance |
| cmd_o | output | 8 | Command byte of the last committed frame |
| data_o | output | 16 | Data word of the last committed frame |
| commit_o | output | 1 | One-cycle strobe: command and data are valid |
| frame_err_o | output | 1 | One-cycle strobe: the window had a bad edge count |

## Verification
The bench targets windows of 23, 25 and zero edges. A port that committed on any count would pass corrupted or misaligned command bytes to the register block. It runs both clock polarities: a design that moved its output on the first falling edge of an idle-high clock would skip the first readback bit. Clock toggles while deselected check that the register is not shifted outside a window; a port that shifted them in would return wrong readback bits. A 48-edge chained window shows whether a port that expects exactly 24 edges would block the chain from committing.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam int unsigned CMD_BITS  = 8;
    localparam int unsigned DATA_BITS = 16;

    // Synchronized pin sample
    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic din;
    } pin_t;

    // Events derived from two successive synchronized samples
    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic cs_fall;
        logic cs_rise;
        logic selected;
        logic din;
    } evt_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } frame_state_e;

    localparam pin_t PIN_RESET = '{sclk: 1'b0, cs_n: 1'b1, din: 1'b0};

    function automatic int unsigned pos_width(input int unsigned frame_bits);
        return (frame_bits < 2) ? 1 : $clog2(frame_bits);
    endfunction

endpackage

// File: rtl/sfs_sync.sv
module sfs_sync
    import sfs_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  pin_t raw_i,
    output pin_t sync_o
);
    pin_t stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stage_q[i] <= PIN_RESET;
            end
        end else begin
            stage_q[0] <= raw_i;
            for (int i = 1; i < int'(STAGES); i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sfs_edge.sv
module sfs_edge
    import sfs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pin_t sync_i,
    output evt_t ev_o
);
    logic sclk_prev_q;
    logic cs_n_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= PIN_RESET.sclk;
            cs_n_prev_q <= PIN_RESET.cs_n;
        end else begin
            sclk_prev_q <= sync_i.sclk;
            cs_n_prev_q <= sync_i.cs_n;
        end
    end

    always_comb begin
        ev_o.sclk_rise = sync_i.sclk & ~sclk_prev_q;
        ev_o.sclk_fall = ~sync_i.sclk & sclk_prev_q;
        ev_o.cs_fall   = cs_n_prev_q & ~sync_i.cs_n;
        ev_o.cs_rise   = ~cs_n_prev_q & sync_i.cs_n;
        ev_o.selected  = ~sync_i.cs_n;
        ev_o.din       = sync_i.din;
    end
endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter
    import sfs_pkg::*;
#(
    parameter int unsigned FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  evt_t               ev_i,
    output logic [FRAME_W-1:0] sr_o,
    output logic               dout_o
);
    logic [FRAME_W-1:0] sr_q;
    logic               dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            dout_q <= 1'b0;
        end else begin
            if (ev_i.selected && ev_i.sclk_rise) begin
                sr_q <= {sr_q[FRAME_W-2:0], ev_i.din};
            end
            if (ev_i.cs_fall || (ev_i.selected && ev_i.sclk_fall)) begin
                dout_q <= sr_q[FRAME_W-1];
            end
        end
    end

    assign sr_o   = sr_q;
    assign dout_o = dout_q;
endmodule

// File: rtl/sfs_frame_ctl.sv
module sfs_frame_ctl
    import sfs_pkg::*;
#(
    parameter int unsigned CMD_W  = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  evt_t                      ev_i,
    input  logic [CMD_W+DATA_W-1:0]   sr_i,
    output logic [CMD_W-1:0]          cmd_o,
    output logic [DATA_W-1:0]         data_o,
    output logic                      commit_o,
    output logic                      frame_err_o
);
    localparam int unsigned FRAME_W = CMD_W + DATA_W;
    localparam int unsigned POS_W   = pos_width(FRAME_W);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_W - 1);

    frame_state_e      state_q;
    logic [POS_W-1:0]  pos_q;     // rising edges modulo frame length
    logic              full_q;    // at least one whole frame seen
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] data_q;
    logic              commit_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pos_q    <= '0;
            full_q   <= 1'b0;
            cmd_q    <= '0;
            data_q   <= '0;
            commit_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            err_q    <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (ev_i.cs_fall) begin
                        state_q <= ST_SHIFT;
                        pos_q   <= ev_i.sclk_rise ? POS_W'(1) : '0;
                        full_q  <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (ev_i.cs_rise) begin
                        state_q <= ST_IDLE;
                        if (full_q && (pos_q == '0)) begin
                            commit_q <= 1'b1;
                            cmd_q    <= sr_i[FRAME_W-1 -: CMD_W];
                            data_q   <= sr_i[DATA_W-1:0];
                        end else begin
                            err_q <= 1'b1;
                        end
                    end else if (ev_i.sclk_rise) begin
                        if (pos_q == POS_LAST) begin
                            pos_q  <= '0;
                            full_q <= 1'b1;
                        end else begin
                            pos_q <= pos_q + POS_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_o       = cmd_q;
    assign data_o      = data_q;
    assign commit_o    = commit_q;
    assign frame_err_o = err_q;
endmodule

// File: rtl/cmdframe_spi_slave.sv
module cmdframe_spi_slave
    import sfs_pkg::*;
#(
    parameter int unsigned CMD_W       = CMD_BITS,
    parameter int unsigned DATA_W      = DATA_BITS,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [DATA_W-1:0] data_o,
    output logic              commit_o,
    output logic              frame_err_o
);
    localparam int unsigned FRAME_W = CMD_W + DATA_W;

    pin_t               raw_w;
    pin_t               sync_w;
    evt_t               ev_w;
    logic [FRAME_W-1:0] sr_w;

    assign raw_w = '{sclk: sclk_i, cs_n: cs_n_i, din: din_i};

    sfs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw_w),
        .sync_o (sync_w)
    );

    sfs_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_w),
        .ev_o   (ev_w)
    );

    sfs_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .ev_i   (ev_w),
        .sr_o   (sr_w),
        .dout_o (dout_o)
    );

    sfs_frame_ctl #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (ev_w),
        .sr_i        (sr_w),
        .cmd_o       (cmd_o),
        .data_o      (data_o),
        .commit_o    (commit_o),
        .frame_err_o (frame_err_o)
    );

    assign dout_oe_o = ev_w.selected;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
    import sfs_pkg::*;
#(
    parameter int unsigned FRAME_W = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               cs_n,
    input logic               oe,
    input logic               commit,
    input logic               ferr,
    input logic [FRAME_W-1:0] sr,
    input logic               dout,
    input evt_t               ev
);
    // R3 / R4: the two strobes never coincide
    a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(commit && ferr));

    // R3: commit lasts a single cycle
    a_r3_commit_single: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R4: error lasts a single cycle
    a_r4_error_single: assert property (@(posedge clk) disable iff (rst)
        ferr |=> !ferr);

    // R3: a commit only follows a closed window
    a_r3_commit_deselected: assert property (@(posedge clk) disable iff (rst)
        commit |-> !oe);

    // R6: output disabled once chip select has been high long enough
    a_r6_oe_off: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !oe);

    // R11: register untouched while deselected
    a_r11_sr_hold: assert property (@(posedge clk) disable iff (rst)
        !ev.selected |=> $stable(sr));

    // R5: output bit moves only on a falling clock or a frame start
    a_r5_dout_hold: assert property (@(posedge clk) disable iff (rst)
        (!ev.sclk_fall && !ev.cs_fall) |=> $stable(dout));
endmodule

bind cmdframe_spi_slave sfs_checker #(.FRAME_W(FRAME_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n_i),
    .oe     (dout_oe_o),
    .commit (commit_o),
    .ferr   (frame_err_o),
    .sr     (sr_w),
    .dout   (dout_o),
    .ev     (ev_w)
);

// File: tb/tb_cmdframe_spi_slave.sv
module tb_cmdframe_spi_slave;
    localparam int HALF = 6;   // system cycles per serial half period

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic din = 1'b0;

    logic        dout_a, oe_a, commit_a, ferr_a;
    logic [7:0]  cmd_a;
    logic [15:0] data_a;
    logic        dout_b, oe_b, commit_b, ferr_b;
    logic [7:0]  cmd_b;
    logic [15:0] data_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int ca_cnt = 0, fa_cnt = 0, cb_cnt = 0, fb_cnt = 0;
    logic [23:0] exp_a = '0;
    logic [23:0] exp_b = '0;

    always #10 clk = ~clk;

    cmdframe_spi_slave dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
        .dout_o(dout_a), .dout_oe_o(oe_a), .cmd_o(cmd_a), .data_o(data_a),
        .commit_o(commit_a), .frame_err_o(ferr_a)
    );

    // downstream port of a two-deep chain
    cmdframe_spi_slave dut_b (
        .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(dout_a),
        .dout_o(dout_b), .dout_oe_o(oe_b), .cmd_o(cmd_b), .data_o(data_b),
        .commit_o(commit_b), .frame_err_o(ferr_b)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (commit_a) ca_cnt++;
            if (ferr_a)   fa_cnt++;
            if (commit_b) cb_cnt++;
            if (ferr_b)   fb_cnt++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit commits(input int n);
        return (n > 0) && (n % 24 == 0);
    endfunction

    task automatic run_frame(input logic [47:0] bits, input int n, input bit idle_high);
        int pa, pfa, pb, pfb;
        pa = ca_cnt; pfa = fa_cnt; pb = cb_cnt; pfb = fb_cnt;
        sclk = idle_high;
        step(HALF);
        cs_n = 1'b0;
        step(HALF);
        chk("R6 oe while selected", 32'(oe_a), 32'd1);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = bits[n-1-i];
            if (idle_high) begin
                sclk = 1'b0;
                step(HALF);
            end
            din = b;
            // R5/R8: bit on the output just before the capturing edge
            chk("R5/R8 dout bit", 32'(dout_a), 32'(exp_a[23]));
            sclk = 1'b1;
            exp_b = {exp_b[22:0], exp_a[23]};
            exp_a = {exp_a[22:0], b};
            step(HALF);
            if (!idle_high) begin
                sclk = 1'b0;
                step(HALF);
            end
        end
        cs_n = 1'b1;
        step(HALF + 2);
        chk("R6 oe after deselect", 32'(oe_a), 32'd0);
        if (commits(n)) begin
            chk("R3 commit count", 32'(ca_cnt), 32'(pa + 1));
            chk("R4 no error", 32'(fa_cnt), 32'(pfa));
            chk("R2/R3 cmd", 32'(cmd_a), 32'(exp_a[23:16]));
            chk("R2/R3 data", 32'(data_a), 32'(exp_a[15:0]));
            chk("R9 chained commit", 32'(cb_cnt), 32'(pb + 1));
            chk("R9 chained frame", 32'({cmd_b, data_b}), 32'(exp_b));
        end else begin
            chk("R4 error count", 32'(fa_cnt), 32'(pfa + 1));
            chk("R4 no commit", 32'(ca_cnt), 32'(pa));
            chk("R4 chained error", 32'(fb_cnt), 32'(pfb + 1));
        end
    endtask

    initial begin
        int unsigned seed_ret;
        seed_ret = $urandom(32'd20240611);
        step(4);
        rst = 1'b0;
        step(3);
        // R10: reset state
        chk("R10 dout", 32'(dout_a), 32'd0);
        chk("R10 oe", 32'(oe_a), 32'd0);
        chk("R10 commit", 32'(commit_a), 32'd0);
        chk("R10 error", 32'(ferr_a), 32'd0);

        // R1: field order, idle-low clock
        run_frame(48'hA5_1234, 24, 1'b0);
        chk("R1 command byte", 32'(cmd_a), 32'hA5);
        chk("R1 data word", 32'(data_a), 32'h1234);

        // R7/R8: idle-high clock, readback of previous frame
        run_frame(48'h3C_BEEF, 24, 1'b1);
        chk("R7 idle-high cmd", 32'(cmd_a), 32'h3C);
        chk("R7 idle-high data", 32'(data_a), 32'hBEEF);

        // R4: short, long and empty windows
        run_frame(48'h7F_FFFF, 23, 1'b0);
        run_frame(48'h1_5555AA, 25, 1'b1);
        run_frame(48'h0, 0, 1'b0);

        // R11: clock activity while deselected is ignored
        begin
            int pa;
            pa = ca_cnt;
            for (int k = 0; k < 10; k++) begin
                din = 1'($urandom);
                sclk = ~sclk;
                step(HALF);
            end
            chk("R11 no strobe while idle", 32'(ca_cnt + fa_cnt), 32'(pa + fa_cnt));
        end
        run_frame(48'h96_0F0F, 24, 1'b0);   // readback proves register unchanged

        // R9: 48-edge chained window
        run_frame(48'hC3_A1B2_5A_7788, 48, 1'b0);
        chk("R9 upstream last frame", 32'({cmd_a, data_a}), 32'h5A7788);
        chk("R9 downstream first frame", 32'({cmd_b, data_b}), 32'hC3A1B2);

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [47:0] bits;
            int sel, n;
            bits = {16'($urandom), $urandom};
            sel = int'($urandom % 8);
            n = (sel == 0) ? 23 : (sel == 1) ? 25 : (sel == 2) ? 48 : 24;
            run_frame(bits, n, 1'($urandom));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule